// File: doc/BRIEF.md
# Cumulative Difference Histogram Period Finder

This block searches a stored list of pulse arrival times for a repeating interval. At each step it takes a separation s, starting at 1. For every pair of stored pulses whose indices differ by s, it forms the later time minus the earlier time. It turns that difference into a histogram bin by dropping the low bits, and adds one to that bin of a histogram. The histogram keeps its contents from one step to the next. After each step the block scans the histogram upward from the shortest interval and looks for the first bin whose count is strictly greater than a threshold.

When a bin passes, the block shows the bin's interval and raises a found flag. It then holds until it receives either a continue command, which starts the next separation, or a stop command. When no bin passes, it goes on to the next separation by itself. The run ends, with done raised, after the last separation or after a stop.

The arrival times come from a memory outside the block. The block drives a read address, and the time and an exclusion flag for that entry return one cycle later. The exclusion flag marks pulses that already belong to a sequence found earlier, and any pair that touches such a pulse is left out. All values are unsigned integers, and the stored times must never decrease as the index rises. The block has no data stream at its edge. Every pin is a plain control or status signal, and the memory port needs no handshake because its latency is fixed.

Top module: `dh_period_finder`

## Requirements
- R1: A start pulse seen while idle clears every histogram bin and latches the pulse count and the top separation. The block then steps the separation up by one at a time, from 1 to that top value. A top value of 0 raises done on the next edge without reading memory.
- R2: For separation s, every index i with i+s below the pulse count adds one to bin (t[i+s]-t[i]) >> 2. Differences of 128 or more (bin 32 and above) are dropped. With the default parameters the highest usable difference is 127, which falls in bin 31.
- R3: The counts from all separations of a run add up in the same bins. The histogram is never reset between separations.
- R4: After each separation the scan returns the lowest bin whose count is strictly greater than the threshold. The threshold is sampled when the scan begins. The reported period is that bin index shifted left by 2.
- R5: When no bin passes, found stays low and the next separation starts with no command needed. After the top separation, done rises and stays high until the next start.
- R6: While found is high, the period is held and the block waits. A continue command drops found and starts the next separation, or ends the run if this was the top one. A stop command drops found and raises done on the next edge.
- R7: A pair is not counted when the exclusion flag of either of its two pulses is set.
- R8: Bin counts stop at 255 instead of wrapping.
- R9: A start pulse is ignored while a run is in progress. This includes a start that arrives while a period is being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| cont | input | 1 | Continue to the next separation while a period is held |
| brk | input | 1 | Stop the run while a period is held |
| pulse_cnt | input | 7 | Number of stored pulses, at most 64 |
| max_lvl | input | 4 | Top separation of the run |
| thresh | input | 8 | A bin passes when its count is strictly greater than this value |
| rd_addr | output | 6 | Memory read address |
| rd_toa | input | 16 | Arrival time of the entry addressed one cycle earlier |
| rd_skip | input | 1 | Exclusion flag of the entry addressed one cycle earlier |
| period | output | 16 | Interval of the passing bin, valid while found is high |
| found | output | 1 | A candidate period is held |
| done | output | 1 | The run has finished |

## Verification
The tests use several patterns. A single regular train checks the bin mapping and shows a result at every separation. A train with gaps that alternate between 0 and 20 only passes the threshold once two separations have added into the same bin, which tells a cumulative histogram apart from a histogram built for one separation at a time. The same train with some pulses excluded gives a different separation at which the period is first reported. A set of identical times piles the counts into bin 0 until they reach the 255 ceiling, which tells saturation apart from wrap-around. Trains with spacings of 127 and 128 sit on either side of the top bin. A high threshold, a stop command, a top separation of 0 and a start sent during a hold test the control paths.

// File: rtl/dh_pkg.sv
package dh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_ACC,
    ST_SCAN,
    ST_HOLD
  } dh_state_e;
endpackage

// File: rtl/dh_bin_map.sv
module dh_bin_map #(
  parameter int TOA_W = 16,
  parameter int SHIFT = 2,
  parameter int BINS  = 32,
  localparam int BIN_W = $clog2(BINS)
) (
  input  logic [TOA_W-1:0] toa_lo,
  input  logic [TOA_W-1:0] toa_hi,
  output logic [BIN_W-1:0] bin,
  output logic             hit
);
  localparam logic [TOA_W-1:0] BINS_T = TOA_W'(BINS);
  logic [TOA_W-1:0] diff;
  logic [TOA_W-1:0] scaled;

  always_comb begin
    diff   = toa_hi - toa_lo;
    scaled = diff >> SHIFT;
    hit    = scaled < BINS_T;
    bin    = scaled[BIN_W-1:0];
  end
endmodule

// File: rtl/dh_hist_bank.sv
module dh_hist_bank #(
  parameter int BINS  = 32,
  parameter int CNT_W = 8,
  localparam int BIN_W = $clog2(BINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [BIN_W-1:0] inc_bin,
  input  logic [BIN_W-1:0] rd_bin,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt [BINS];

  for (genvar g = 0; g < BINS; g++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (clr)
        cnt[g] <= '0;
      else if (inc && inc_bin == BIN_W'(g) && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + 1'b1;
    end

    // R3: counts only grow between clears
    p_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt[g] >= $past(cnt[g])));
    // R8: a full bin stays full
    p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == CNT_MAX && !clr) |=> (cnt[g] == CNT_MAX));
  end

  assign rd_cnt = cnt[rd_bin];
endmodule

// File: rtl/dh_period_finder.sv
module dh_period_finder #(
  parameter int TOA_W = 16,
  parameter int N_MAX = 64,
  parameter int LVL_W = 4,
  parameter int BINS  = 32,
  parameter int SHIFT = 2,
  parameter int CNT_W = 8,
  localparam int IDX_W  = $clog2(N_MAX),
  localparam int NCNT_W = IDX_W + 1,
  localparam int BIN_W  = $clog2(BINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cont,
  input  logic              brk,
  input  logic [NCNT_W-1:0] pulse_cnt,
  input  logic [LVL_W-1:0]  max_lvl,
  input  logic [CNT_W-1:0]  thresh,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [TOA_W-1:0]  rd_toa,
  input  logic              rd_skip,
  output logic [TOA_W-1:0]  period,
  output logic              found,
  output logic              done
);
  import dh_pkg::*;

  dh_state_e         state_q;
  logic [LVL_W-1:0]  lvl_q, maxl_q;
  logic [NCNT_W-1:0] i_q, n_q;
  logic [CNT_W-1:0]  thr_q;
  logic [TOA_W-1:0]  toa_a;
  logic              skip_a;
  logic [BIN_W-1:0]  scan_j;
  logic [TOA_W-1:0]  period_q;
  logic              found_q, done_q;

  logic [BIN_W-1:0]  map_bin;
  logic              map_hit;
  logic              bank_clr, bank_inc;
  logic [CNT_W-1:0]  scan_cnt;
  logic              lvl_last, nx_has_pairs, more_pairs;
  logic [LVL_W-1:0]  lvl_nx;

  dh_bin_map #(.TOA_W(TOA_W), .SHIFT(SHIFT), .BINS(BINS)) u_map (
    .toa_lo(toa_a), .toa_hi(rd_toa), .bin(map_bin), .hit(map_hit)
  );

  assign bank_clr = (state_q == ST_IDLE) && start && (max_lvl != '0);
  assign bank_inc = (state_q == ST_ACC) && map_hit && !skip_a && !rd_skip;

  dh_hist_bank #(.BINS(BINS), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(bank_clr), .inc(bank_inc),
    .inc_bin(map_bin), .rd_bin(scan_j), .rd_cnt(scan_cnt)
  );

  assign rd_addr = IDX_W'((state_q == ST_RDB) ? int'(i_q) + int'(lvl_q) : int'(i_q));

  always_comb begin
    lvl_last     = (lvl_q == maxl_q);
    lvl_nx       = lvl_q + 1'b1;
    nx_has_pairs = int'(lvl_nx) < int'(n_q);
    more_pairs   = (int'(i_q) + 1 + int'(lvl_q)) < int'(n_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q <= '0; maxl_q <= '0; i_q <= '0; n_q <= '0;
      thr_q <= '0; toa_a <= '0; skip_a <= 1'b0; scan_j <= '0;
      period_q <= '0; found_q <= 1'b0; done_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          n_q <= pulse_cnt; maxl_q <= max_lvl; found_q <= 1'b0;
          if (max_lvl == '0) begin
            done_q <= 1'b1;
          end else begin
            done_q <= 1'b0; lvl_q <= LVL_W'(1); i_q <= '0;
            scan_j <= '0; thr_q <= thresh;
            state_q <= (1 < int'(pulse_cnt)) ? ST_RDA : ST_SCAN;
          end
        end
        ST_RDA: state_q <= ST_RDB;
        ST_RDB: begin
          toa_a <= rd_toa; skip_a <= rd_skip; state_q <= ST_ACC;
        end
        ST_ACC: begin
          i_q <= i_q + 1'b1;
          if (more_pairs) state_q <= ST_RDA;
          else begin
            scan_j <= '0; thr_q <= thresh; state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_cnt > thr_q) begin
            found_q  <= 1'b1;
            period_q <= TOA_W'(scan_j) << SHIFT;
            state_q  <= ST_HOLD;
          end else if (int'(scan_j) == BINS - 1) begin
            if (lvl_last) begin
              done_q <= 1'b1; state_q <= ST_IDLE;
            end else begin
              lvl_q <= lvl_nx; i_q <= '0; scan_j <= '0; thr_q <= thresh;
              state_q <= nx_has_pairs ? ST_RDA : ST_SCAN;
            end
          end else begin
            scan_j <= scan_j + 1'b1;
          end
        end
        ST_HOLD: begin
          if (brk) begin
            found_q <= 1'b0; done_q <= 1'b1; state_q <= ST_IDLE;
          end else if (cont) begin
            found_q <= 1'b0;
            if (lvl_last) begin
              done_q <= 1'b1; state_q <= ST_IDLE;
            end else begin
              lvl_q <= lvl_nx; i_q <= '0; scan_j <= '0; thr_q <= thresh;
              state_q <= nx_has_pairs ? ST_RDA : ST_SCAN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign period = period_q;
  assign found  = found_q;
  assign done   = done_q;

  // R6: a held period is only visible in the hold state
  p_found_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (state_q == ST_HOLD));
  // R6: with no command the hold persists and the period is steady
  p_hold_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !cont && !brk) |=> (found && $stable(period)));
  // R5: done is only shown while idle
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_q == ST_IDLE));
  // R2: reads never pass the stored pulse count
  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDA || state_q == ST_RDB) |-> (int'(rd_addr) < int'(n_q)));
  // R4: a reported period lies inside the histogram span
  p_period_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (int'(period) < (BINS << SHIFT)));
  // R9: a start during a hold does not leave the hold
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && start && !cont && !brk) |=> (state_q == ST_HOLD));
endmodule

// File: tb/dh_period_finder_tb.sv
module dh_period_finder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cont = 1'b0, brk = 1'b0;
  logic [6:0] pulse_cnt = '0;
  logic [3:0] max_lvl = '0;
  logic [7:0] thresh = '0;
  logic [5:0] rd_addr;
  logic [15:0] rd_toa;
  logic rd_skip;
  logic [15:0] period;
  logic found, done;

  logic [15:0] mem [64];
  logic        skp [64];
  int exp_per [16];
  int exp_n;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    rd_toa  <= mem[rd_addr];
    rd_skip <= skp[rd_addr];
  end

  dh_period_finder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cont(cont), .brk(brk),
    .pulse_cnt(pulse_cnt), .max_lvl(max_lvl), .thresh(thresh),
    .rd_addr(rd_addr), .rd_toa(rd_toa), .rd_skip(rd_skip),
    .period(period), .found(found), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic fill(input int n, input int base, input int step);
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'(base + step * i);
      skp[i] = 1'b0;
    end
  endtask

  task automatic model(input int n, input int maxl, input int thr);
    int cum [NB];
    exp_n = 0;
    for (int b = 0; b < NB; b++) cum[b] = 0;
    for (int k = 1; k <= maxl; k++) begin
      for (int i = 0; i + k < n; i++) begin
        if (!skp[i] && !skp[i+k]) begin
          int d = int'(mem[i+k]) - int'(mem[i]);
          int b = d >> 2;
          if (d >= 0 && b < NB && cum[b] < 255) cum[b]++;
        end
      end
      for (int b = 0; b < NB; b++) begin
        if (cum[b] > thr) begin
          exp_per[exp_n] = b * 4;
          exp_n++;
          break;
        end
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_evt(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (found || done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_case(input string req, input int n, input int maxl,
                          input int thr, input int brk_at);
    bit ok;
    int idx = 0;
    model(n, maxl, thr);
    pulse_cnt = 7'(n); max_lvl = 4'(maxl); thresh = 8'(thr);
    pulse_start();
    forever begin
      wait_evt(ok);
      if (!ok) begin
        check(1'b0, {req, " timeout"}, 0, 1);
        break;
      end
      if (found) begin
        check(idx < exp_n && int'(period) == exp_per[idx], {req, " period"},
              int'(period), (idx < exp_n) ? exp_per[idx] : -1);
        if (idx == brk_at) begin
          @(negedge clk) brk = 1'b1;
          @(negedge clk) brk = 1'b0;
          check(done && !found, "R6 stop ends run", int'(done), 1);
          break;
        end
        idx++;
        @(negedge clk) cont = 1'b1;
        @(negedge clk) cont = 1'b0;
      end else begin
        check(idx == exp_n, {req, " report count"}, idx, exp_n);
        break;
      end
    end
  endtask

  task automatic tc_reset();
    check(!found && !done, "R1 reset state", int'({found, done}), 0);
  endtask

  task automatic tc_single();
    fill(8, 5, 20);
    run_case("R1 R2 single train", 8, 3, 3, -1);
    check(exp_n == 3, "R1 levels in order", exp_n, 3);
  endtask

  task automatic tc_cumulative();
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'(20 * (i / 2));
      skp[i] = 1'b0;
    end
    run_case("R3 R5 cumulative", 12, 3, 12, -1);
    check(exp_n > 0 && exp_per[0] == 20, "R3 first find", exp_per[0], 20);
  endtask

  task automatic tc_none();
    fill(8, 5, 20);
    run_case("R5 no pass", 8, 4, 250, -1);
  endtask

  task automatic tc_stop();
    fill(8, 5, 20);
    run_case("R6 stop", 8, 4, 3, 0);
  endtask

  task automatic tc_skip();
    fill(8, 5, 20);
    skp[2] = 1'b1; skp[5] = 1'b1;
    run_case("R7 exclusion", 8, 4, 3, -1);
    check(exp_n > 0 && exp_per[0] == 60, "R7 first find", exp_per[0], 60);
  endtask

  task automatic tc_sat();
    fill(64, 100, 0);
    run_case("R8 saturation", 64, 6, 254, -1);
    fill(64, 100, 0);
    run_case("R8 ceiling", 64, 6, 255, -1);
  endtask

  task automatic tc_range();
    fill(8, 0, 127);
    run_case("R2 top bin", 8, 2, 0, -1);
    fill(8, 0, 128);
    run_case("R2 beyond top", 8, 2, 0, -1);
  endtask

  task automatic tc_zero();
    fill(8, 5, 20);
    run_case("R1 zero top", 8, 0, 0, -1);
    check(done == 1'b1, "R1 zero top done", int'(done), 1);
  endtask

  task automatic tc_busy();
    bit ok;
    fill(8, 5, 20);
    pulse_cnt = 7'd8; max_lvl = 4'd2; thresh = 8'd3;
    pulse_start();
    wait_evt(ok);
    check(ok && found && period == 16'd20, "R9 hold reached", int'(period), 20);
    pulse_start();
    @(negedge clk);
    check(found && period == 16'd20, "R9 start ignored", int'(found), 1);
    @(negedge clk) brk = 1'b1;
    @(negedge clk) brk = 1'b0;
    check(done == 1'b1, "R9 stop after ignore", int'(done), 1);
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    fill(8, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tc_reset();
    tc_single();
    tc_cumulative();
    tc_none();
    tc_stop();
    tc_skip();
    tc_sat();
    tc_range();
    tc_zero();
    tc_busy();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule